// File: doc/BRIEF.md
# Multiplexed Bus Read Sequencer

This block masters read cycles on a multiplexed bus: an 8-bit lane that first carries the low address byte and then the read data, plus a separate upper address lane for the high byte. A read starts with a one-cycle request carrying a 16-bit address and an extended flag. With the flag set, the high byte is presented in an extra opening phase. Without it, that phase is left out. The sequencer then presents the low byte, waits one clock of setup, pulses the address latch strobe, asserts chip select, releases the lane and drives the read strobe low. When the read strobe returns high, it returns the captured byte with a one-cycle done pulse.

A ready input lengthens three of the phases. It does not add open-ended waits. If ready is seen low in the first cycle of a stretchable phase, that phase runs to a fixed longer length. Chip select is released half a bus clock after the read strobe. A flop clocked on the falling edge produces this offset, and the lane is driven again at the same moment.

Top module: `mux_rd_seq`

## Requirements
- R1: While reset is held, ale_o is 0, cs_n_o and rd_n_o are 1, ad_oe is 1, ad_o is 0 and rsp_valid is 0.
- R2: With req_ext=1, ale_o rises 3 clocks after the accepting edge and addr_hi_oe is 1 with addr_hi_o equal to req_addr[15:8]. With req_ext=0, ale_o rises 2 clocks after that edge and addr_hi_oe is 0.
- R3: When ale_o rises, ad_oe is 1 and ad_o equals req_addr[7:0]; this value has been on the lane for at least one full clock.
- R4: ale_o stays high 1 clock when ioready is 1 in its first cycle, and 2 clocks when it is 0.
- R5: cs_n_o falls exactly one clock after ale_o rises, for either ioready level.
- R6: From the fall of ale_o to the fall of rd_n_o, chip select is low for 1 clock, or 3 clocks when ioready is 0 in the first cycle of that phase.
- R7: rd_n_o stays low 1 clock, or 5 clocks when ioready is 0 in its first cycle; ad_oe falls together with rd_n_o.
- R8: cs_n_o rises half a clock after rd_n_o rises, and ad_oe returns to 1 at that same instant.
- R9: rsp_data holds the value of ad_i sampled on the edge where rd_n_o rises, and rsp_valid is high for exactly the one clock after that edge.
- R10: A req_valid pulse that arrives while a read is in progress is ignored: it starts no further cycle and does not alter the address of the current read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle read request |
| req_addr | input | 16 | Read address |
| req_ext | input | 1 | 1 = present the high address byte in an opening phase |
| ioready | input | 1 | 0 = stretch the current stretchable phase |
| ad_i | input | 8 | Lane value seen from the bus |
| ad_o | output | 8 | Lane value driven onto the bus |
| ad_oe | output | 1 | 1 = lane driven, 0 = lane high impedance |
| addr_hi_o | output | 8 | High address byte |
| addr_hi_oe | output | 1 | High address lane valid |
| ale_o | output | 1 | Address latch strobe, active high |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | 8 | Captured read byte |

## Verification
Reads are run with all four combinations of the extended flag and a high or low ready level. The flag shows up in when the latch strobe rises, and the ready level shows up in how long each strobe lasts. Edge times of every strobe are recorded, so the one-clock chip-select lead, the half-clock release offset and the lane re-drive instant are measured directly rather than sampled. Two reads carry a stray request in the middle of the cycle. The strobe-rise count and the latched address show whether that request leaked through.

// File: rtl/mrs_pkg.sv
`timescale 1ns/1ps
package mrs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HIGH,
      PH_LOW,
      PH_SETUP,
      PH_LATCH,
      PH_SELECT,
      PH_READ
   } phase_e;
endpackage

// File: rtl/mrs_phase_timer.sv
`timescale 1ns/1ps
module mrs_phase_timer
   import mrs_pkg::*;
#(
   parameter int LATCH_LONG  = 2,
   parameter int SELECT_LONG = 3,
   parameter int READ_LONG   = 5
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e ph,
   input  logic   ready,
   output logic   first_cyc,
   output logic   last_cyc
);
   localparam int MAX_A = (LATCH_LONG > SELECT_LONG) ? LATCH_LONG : SELECT_LONG;
   localparam int MAX_L = (MAX_A > READ_LONG) ? MAX_A : READ_LONG;
   localparam int CNT_W = (MAX_L > 1) ? $clog2(MAX_L) : 1;
   localparam logic [CNT_W-1:0] LATCH_END  = CNT_W'(LATCH_LONG - 1);
   localparam logic [CNT_W-1:0] SELECT_END = CNT_W'(SELECT_LONG - 1);
   localparam logic [CNT_W-1:0] READ_END   = CNT_W'(READ_LONG - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] end_val;

   always_comb begin
      case (ph)
         PH_LATCH:  end_val = LATCH_END;
         PH_SELECT: end_val = SELECT_END;
         PH_READ:   end_val = READ_END;
         default:   end_val = '0;
      endcase
   end

   assign first_cyc = (cnt == '0);
   // ready is looked at only in the first cycle; once low, the phase runs to its long length
   assign last_cyc  = (ph != PH_IDLE) && ((first_cyc && ready) || (cnt == end_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (last_cyc || ph == PH_IDLE)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mrs_strobe_dec.sv
`timescale 1ns/1ps
module mrs_strobe_dec
   import mrs_pkg::*;
(
   input  phase_e ph,
   input  logic   first_cyc,
   output logic   ale,
   output logic   cs_req,
   output logic   rd_act
);
   // chip select joins in the second cycle of the latch phase, so it trails the strobe rise by one clock
   assign ale    = (ph == PH_LATCH);
   assign cs_req = (ph == PH_LATCH && !first_cyc) || (ph == PH_SELECT) || (ph == PH_READ);
   assign rd_act = (ph == PH_READ);
endmodule

// File: rtl/mrs_half_tail.sv
`timescale 1ns/1ps
module mrs_half_tail #(
   parameter bit HALF_TAIL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_req,
   input  logic rd_act,
   output logic cs_n,
   output logic ad_oe
);
   logic cs_q;
   logic rd_q;

   generate
      if (HALF_TAIL) begin : g_neg
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_q <= 1'b0;
               rd_q <= 1'b0;
            end else begin
               cs_q <= cs_req;
               rd_q <= rd_act;
            end
         end
      end else begin : g_pos
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_q <= 1'b0;
               rd_q <= 1'b0;
            end else begin
               cs_q <= cs_req;
               rd_q <= rd_act;
            end
         end
      end
   endgenerate

   // assert at once, release only after the delayed copy has dropped
   assign cs_n  = ~(cs_req | cs_q);
   assign ad_oe = ~(rd_act | rd_q);
endmodule

// File: rtl/mux_rd_seq.sv
`timescale 1ns/1ps
module mux_rd_seq
   import mrs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 16,
   parameter int LATCH_LONG  = 2,
   parameter int SELECT_LONG = 3,
   parameter int READ_LONG   = 5,
   parameter bit HALF_TAIL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_ext,
   input  logic              ioready,
   input  logic [DATA_W-1:0] ad_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   output logic [DATA_W-1:0] addr_hi_o,
   output logic              addr_hi_oe,
   output logic              ale_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   localparam int HI_LSB = ADDR_W - DATA_W;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must be twice DATA_W");
      end
      if (LATCH_LONG < 1 || SELECT_LONG < 1 || READ_LONG < 1) begin : g_bad_len
         $error("stretched phase lengths must be at least one clock");
      end
   endgenerate

   phase_e           ph;
   phase_e           ph_nx;
   logic             first_cyc;
   logic             last_cyc;
   logic             ale;
   logic             cs_req;
   logic             rd_act;
   logic             ext_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_q;
   logic [DATA_W-1:0] ad_q;

   mrs_phase_timer #(
      .LATCH_LONG (LATCH_LONG),
      .SELECT_LONG(SELECT_LONG),
      .READ_LONG  (READ_LONG)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .ready    (ioready),
      .first_cyc(first_cyc),
      .last_cyc (last_cyc)
   );

   mrs_strobe_dec u_dec (
      .ph       (ph),
      .first_cyc(first_cyc),
      .ale      (ale),
      .cs_req   (cs_req),
      .rd_act   (rd_act)
   );

   mrs_half_tail #(.HALF_TAIL(HALF_TAIL)) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_req(cs_req),
      .rd_act(rd_act),
      .cs_n  (cs_n_o),
      .ad_oe (ad_oe)
   );

   always_comb begin
      ph_nx = ph;
      if (ph == PH_IDLE) begin
         if (req_valid) ph_nx = req_ext ? PH_HIGH : PH_LOW;
      end else if (last_cyc) begin
         case (ph)
            PH_HIGH:   ph_nx = PH_LOW;
            PH_LOW:    ph_nx = PH_SETUP;
            PH_SETUP:  ph_nx = PH_LATCH;
            PH_LATCH:  ph_nx = PH_SELECT;
            PH_SELECT: ph_nx = PH_READ;
            default:   ph_nx = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_IDLE;
         ext_q     <= 1'b0;
         lo_q      <= '0;
         hi_q      <= '0;
         ad_q      <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         ph        <= ph_nx;
         rsp_valid <= 1'b0;
         if (ph == PH_IDLE && req_valid) begin
            ext_q <= req_ext;
            lo_q  <= req_addr[DATA_W-1:0];
            if (req_ext) hi_q <= req_addr[HI_LSB +: DATA_W];
            else         ad_q <= req_addr[DATA_W-1:0];
         end
         if (ph == PH_HIGH && last_cyc) ad_q <= lo_q;
         if (ph == PH_READ && last_cyc) begin
            rsp_data  <= ad_i;
            rsp_valid <= 1'b1;
         end
      end
   end

   assign ad_o       = ad_q;
   assign addr_hi_o  = hi_q;
   assign addr_hi_oe = ext_q && (ph != PH_IDLE);
   assign ale_o      = ale;
   assign rd_n_o     = ~rd_act;
endmodule

// File: rtl/mrs_chk.sv
`timescale 1ns/1ps
module mrs_chk (
   input logic clk,
   input logic rst_n,
   input logic ale_o,
   input logic cs_n_o,
   input logic rd_n_o,
   input logic ad_oe,
   input logic rsp_valid
);
   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!ale_o && cs_n_o && rd_n_o && ad_oe && !rsp_valid); // R1
      end
   end

   AST_ALE_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (ale_o && $past(ale_o)) |=> !ale_o); // R4
   AST_CS_HIGH_AT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_o) |-> cs_n_o); // R5
   AST_CS_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_o) |=> !cs_n_o); // R5
   AST_NO_ALE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !ale_o); // R6
   AST_READ_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !cs_n_o); // R7
   AST_LANE_FREE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !ad_oe); // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R9
   AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(!rd_n_o)); // R9
endmodule

bind mux_rd_seq mrs_chk u_chk (.*);

// File: tb/sim_mux_rd_seq.sv
`timescale 1ns/1ps
module sim_mux_rd_seq;
   typedef struct {
      logic [15:0] addr;
      logic        ext;
      logic        rdy;
      logic [7:0]  data;
      realtime     t_acc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_ext = 1'b0;
   logic        ioready = 1'b1;
   logic [7:0]  ad_i = '0;
   logic [7:0]  ad_o;
   logic        ad_oe;
   logic [7:0]  addr_hi_o;
   logic        addr_hi_oe;
   logic        ale_o;
   logic        cs_n_o;
   logic        rd_n_o;
   logic        rsp_valid;
   logic [7:0]  rsp_data;

   int   n_chk = 0;
   int   n_bad = 0;
   int   n_issued = 0;
   int   n_rsp = 0;
   int   n_ale = 0;
   bit   finished = 1'b0;
   exp_t q[$];

   realtime t_ale_r, t_ale_f, t_cs_f, t_cs_r, t_rd_f, t_rd_r, t_oe_f, t_oe_r;

   always #4 clk = ~clk;

   mux_rd_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ext(req_ext), .ioready(ioready), .ad_i(ad_i), .ad_o(ad_o),
      .ad_oe(ad_oe), .addr_hi_o(addr_hi_o), .addr_hi_oe(addr_hi_oe),
      .ale_o(ale_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic chk(string rq, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic longint ps(realtime d);
      return longint'(d * 1000.0);
   endfunction

   always @(posedge ale_o) begin
      t_ale_r = $realtime;
      n_ale++;
      if (q.size() > 0) begin
         chk("R2", "ale lead ps", ps(t_ale_r - q[0].t_acc), q[0].ext ? 24000 : 16000);
         chk("R2", "addr_hi_oe", addr_hi_oe, q[0].ext);
         if (q[0].ext) chk("R2", "addr_hi_o", addr_hi_o, q[0].addr[15:8]);
         chk("R3", "ad_oe at ale", ad_oe, 1);
         chk("R3", "ad_o at ale", ad_o, q[0].addr[7:0]);
      end
   end
   always @(negedge ale_o)  t_ale_f = $realtime;
   always @(negedge cs_n_o) t_cs_f  = $realtime;
   always @(posedge cs_n_o) t_cs_r  = $realtime;
   always @(negedge rd_n_o) t_rd_f  = $realtime;
   always @(posedge rd_n_o) t_rd_r  = $realtime;
   always @(negedge ad_oe)  t_oe_f  = $realtime;
   always @(posedge ad_oe)  t_oe_r  = $realtime;

   // monitor: pops one expected read per done pulse
   bit prev_rsp = 1'b0;
   always begin
      @(posedge clk);
      #5;
      if (rsp_valid && rst_n) begin
         if (prev_rsp) chk("R9", "done pulse longer than one clock", 1, 0);
         if (q.size() == 0) begin
            chk("R10", "unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            n_rsp++;
            chk("R9", "rsp_data", rsp_data, e.data);
            chk("R4", "ale width ps", ps(t_ale_f - t_ale_r), e.rdy ? 8000 : 16000);
            chk("R5", "cs fall after ale rise ps", ps(t_cs_f - t_ale_r), 8000);
            chk("R6", "select phase ps", ps(t_rd_f - t_ale_f), e.rdy ? 8000 : 24000);
            chk("R7", "rd low ps", ps(t_rd_r - t_rd_f), e.rdy ? 8000 : 40000);
            chk("R7", "lane release vs rd fall ps", ps(t_oe_f - t_rd_f), 0);
            chk("R8", "cs rise after rd rise ps", ps(t_cs_r - t_rd_r), 4000);
            chk("R8", "lane redrive vs cs rise ps", ps(t_oe_r - t_cs_r), 0);
         end
      end
      prev_rsp = rsp_valid;
   end

   task automatic issue(logic [15:0] addr, logic ext, logic rdy, logic [7:0] data, bit stray);
      exp_t e;
      @(negedge clk);
      req_addr  = addr;
      req_ext   = ext;
      ioready   = rdy;
      ad_i      = data;
      req_valid = 1'b1;
      e.addr = addr; e.ext = ext; e.rdy = rdy; e.data = data; e.t_acc = $realtime + 4.0;
      q.push_back(e);
      n_issued++;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ~addr;
      if (stray) begin
         // R10: a request arriving mid-cycle must not start or disturb anything
         repeat (2) @(negedge clk);
         req_valid = 1'b1;
         req_ext   = ~ext;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #10;
      chk("R1", "ale in reset", ale_o, 0);
      chk("R1", "cs_n in reset", cs_n_o, 1);
      chk("R1", "rd_n in reset", rd_n_o, 1);
      chk("R1", "ad_oe in reset", ad_oe, 1);
      chk("R1", "ad_o in reset", ad_o, 0);
      chk("R1", "rsp_valid in reset", rsp_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      issue(16'h1234, 1'b0, 1'b1, 8'hA5, 1'b0);
      issue(16'hBEEF, 1'b1, 1'b1, 8'h3C, 1'b0);
      issue(16'h00FF, 1'b0, 1'b0, 8'h81, 1'b0);
      issue(16'h8001, 1'b1, 1'b0, 8'h7E, 1'b0);
      issue(16'h5A5A, 1'b0, 1'b1, 8'hC3, 1'b1);
      issue(16'hC0DE, 1'b1, 1'b0, 8'h19, 1'b1);
      repeat (20) @(negedge clk);
      chk("R10", "latch strobe count", n_ale, n_issued);
      chk("R10", "done count", n_rsp, n_issued);
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule